// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-line general-purpose I/O port on a small byte-wide register bus. The bus has an address, a write strobe, write data and combinational read data. A direction register marks each line as input or output. A data register holds the value driven on the output lines.

Software reaches the data register through a window of offsets. Address bits [9:2] of each access act as a per-line mask, so one write changes only the selected lines and leaves the others alone. In the same way, one read returns only the selected lines and zero in every other bit. Software can therefore set or clear a single pin with one write, with no read-modify-write.

Input lines pass through a two-flop synchronizer before they reach the read path.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the direction and output registers are zero. pin_oe and pin_out are 0, and every read returns 0 while the inputs are low.
- R2: The direction register sits at offset 0x400. Writing it sets pin_oe on the next clock edge. Bit n = 1 makes line n an output. A read at 0x400 returns the register.
- R3: A write anywhere in offsets 0x000 to 0x3FC is a data write. Address bit n+2 is the mask bit for line n. Only output lines whose mask bit is 1 take the new value. All other output bits keep their value.
- R4: A data read returns 0 in every bit whose mask bit is 0.
- R5: For a line set as output, a masked data read returns the value the block drives on that line.
- R6: For a line set as input, a masked data read returns pin_in sampled through two flops. A change made before a clock edge is visible on the read data after the second rising edge and not after the first.
- R7: A data write to a line that is an input has no lasting effect. If the line is later made an output, it drives the value it held before that write.
- R8: Reads from any other offset return 0. Writes to any other offset change neither the direction register nor the output register.
- R9: pin_out is 0 on every line set as input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pin_in | input | 8 | Asynchronous line inputs |
| pin_out | output | 8 | Driven line values |
| pin_oe | output | 8 | Per-line output enable |

## Verification
A wrong mask decode shows at once: after one write, a neighbouring line on pin_out changes or fails to change. The same fault shows on the next masked read as a bit that should be zero. A stale or corrupted direction bit changes pin_oe one edge after the write. It also switches that bit of the read data between the driven value and the synchronized input. A wrong synchronizer depth shifts by a cycle the moment a pin change appears on the read data. The bench checks that moment on both sides of the second edge.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int          LINES      = 8,
  parameter int          ADDR_W     = 12,
  parameter logic [11:0] DIR_OFFSET = 12'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  input  logic [LINES-1:0]  pin_in,
  output logic [LINES-1:0]  pin_out,
  output logic [LINES-1:0]  pin_oe
);
  localparam int MASK_LO = 2;
  localparam int MASK_HI = MASK_LO + LINES - 1;

  logic [LINES-1:0] dir_q, out_q, sync_a, sync_b;
  logic [LINES-1:0] sel, line_val;
  logic             in_data, in_dir;

  assign in_data  = (bus_addr[ADDR_W-1:MASK_HI+1] == '0);
  assign in_dir   = (bus_addr == ADDR_W'(DIR_OFFSET));
  assign sel      = bus_addr[MASK_HI:MASK_LO];
  assign line_val = (dir_q & out_q) | (~dir_q & sync_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= pin_in;
      sync_b <= sync_a;
      if (bus_wr && in_dir)
        dir_q <= bus_wdata;
      if (bus_wr && in_data)
        out_q <= (out_q & ~(sel & dir_q)) | (bus_wdata & sel & dir_q);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_data)
      bus_rdata = line_val & sel;
    else if (in_dir)
      bus_rdata = dir_q;
  end

  assign pin_out = out_q & dir_q;
  assign pin_oe  = dir_q;
endmodule

module gpio_mask_port_chk #(
  parameter int          LINES      = 8,
  parameter int          ADDR_W     = 12,
  parameter logic [11:0] DIR_OFFSET = 12'h400
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [LINES-1:0]  bus_wdata,
  input logic [LINES-1:0]  bus_rdata,
  input logic [LINES-1:0]  pin_out,
  input logic [LINES-1:0]  pin_oe
);
  localparam int HI = LINES + 1;
  logic dwin, dreg;
  logic [LINES-1:0] m;
  assign dwin = (bus_addr[ADDR_W-1:HI+1] == '0);
  assign dreg = (bus_addr == ADDR_W'(DIR_OFFSET));
  assign m    = bus_addr[HI:2];

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && dreg |=> pin_oe == $past(bus_wdata));

  // R3
  unmasked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && dwin |=> (pin_out & ~$past(m)) == ($past(pin_out) & ~$past(m)));

  // R4
  read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dwin |-> (bus_rdata & ~m) == '0);

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dwin && !dreg |-> bus_rdata == '0);

  // R8
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !dwin && !dreg |=> $stable(pin_oe) && $stable(pin_out));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.LINES(LINES), .ADDR_W(ADDR_W), .DIR_OFFSET(DIR_OFFSET)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_mask_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [11:0] dofs(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_out, 8'h00);
    rd(dofs(8'hFF), d); check("R1 data", d, 8'h00);
    rd(12'h400, d);     check("R1 dir", d, 8'h00);
  endtask

  task automatic t_dir;
    logic [7:0] d;
    wr(12'h400, 8'hF0);
    check("R2 oe", pin_oe, 8'hF0);
    rd(12'h400, d); check("R2 read", d, 8'hF0);
  endtask

  task automatic t_masked_write;
    logic [7:0] d;
    wr(dofs(8'hFF), 8'hA0);
    check("R3 full", pin_out, 8'hA0);
    wr(dofs(8'h10), 8'hFF);
    check("R3 single", pin_out, 8'hB0);
    wr(dofs(8'hC0), 8'h00);
    check("R3 pair", pin_out, 8'h30);
    rd(dofs(8'hF0), d); check("R5 read out", d, 8'h30);
    rd(dofs(8'h20), d); check("R4 masked", d, 8'h20);
    rd(dofs(8'h00), d); check("R4 none", d, 8'h00);
  endtask

  task automatic t_input_sync;
    logic [7:0] d;
    @(negedge clk); pin_in = 8'h0F; bus_addr = dofs(8'h0F);
    @(negedge clk); #1 check("R6 one edge", bus_rdata, 8'h00);
    @(negedge clk); #1 check("R6 two edges", bus_rdata, 8'h0F);
    rd(dofs(8'h05), d); check("R6 masked", d, 8'h05);
    pin_in = 8'hFF;
    @(negedge clk); @(negedge clk);
    rd(dofs(8'hFF), d); check("R5 R6 mixed", d, 8'h3F);
  endtask

  task automatic t_input_write;
    logic [7:0] d;
    wr(dofs(8'h01), 8'h01);
    check("R9 input low", pin_out, 8'h30);
    wr(12'h400, 8'hF1);
    check("R7 no effect", pin_out, 8'h30);
    rd(dofs(8'h01), d); check("R7 read", d, 8'h00);
    wr(dofs(8'h01), 8'h01);
    check("R7 after dir", pin_out, 8'h31);
    wr(12'h400, 8'h01);
    check("R9 mask inputs", pin_out, 8'h01);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    wr(12'h404, 8'hFF);
    wr(12'h800, 8'h00);
    check("R8 oe kept", pin_oe, 8'h01);
    check("R8 out kept", pin_out, 8'h01);
    rd(12'h404, d); check("R8 read", d, 8'h00);
    rd(12'hC3C, d); check("R8 read hi", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dir();
    t_masked_write();
    t_input_sync();
    t_input_write();
    t_unmapped();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule